// File: doc/BRIEF.md
# AC Disconnect Discharge Sequencer

This block is the control state machine that decides whether a mains-powered converter has been unplugged. Once it has decided, it runs a timed discharge of the capacitor in the input interference filter. Most of the time it sits in an idle interval with the sensing current off. When that interval ends, it raises a test current in a staircase of four levels while it watches for zero-crossing pulses. The staircase is there so that a small reverse leakage in the rectifier cannot hide a real crossing.

A single crossing at any level shows that the line is still present. The sequencer then drops the test current and starts a new idle interval. If four crossing windows in a row pass without a crossing while the top level is applied, the line is declared gone. The block then enables the discharge current sink for a fixed time.

When the converter is in its latched-off state, the high-voltage pass device also feeds the supply pin through a switch. In that state the sequencer first opens that switch and only then starts the discharge. It closes the switch again after the discharge has ended.

All timing counts pulses of a one-millisecond tick input. Detection runs in every operating mode. The zero-crossing input is expected to be already synchronised and one clock wide.

Top module: `acdseq_top`

## Requirements
- R1: After reset, or on any entry to idle, the test current stays off for exactly 700 ticks. On the 700th tick `test_on` rises with `test_level` = 0. Crossing pulses received during idle neither shorten nor restart this interval.
- R2: Levels 0, 1 and 2 each last 12 ticks and then step up by one. `test_level` is a 2-bit code, 0 lowest and 3 highest, and it never changes by anything other than +1 while `test_on` is high.
- R3: A crossing pulse at any level makes `test_on` low on the next clock. The block returns to idle with a fresh 700-tick interval and forgets any windows already missed.
- R4: Disconnect is confirmed on the tick that closes the fourth consecutive 12-tick window at level 3 with no crossing, which is 48 ticks after level 3 begins. A crossing in the same cycle as that closing tick counts as a crossing: the result is an abort, not a confirmation.
- R5: If `latched` is low when disconnect is confirmed, `dis_en` rises in the same clock in which `test_on` falls. It stays high for 350 ticks, and `sw_open` stays low throughout.
- R6: If `latched` is high when disconnect is confirmed, `sw_open` rises first and `dis_en` rises one tick later. `dis_en` stays high for 350 ticks, and `sw_open` falls one tick after `dis_en` falls. `dis_en` is never high without `sw_open` in this sequence.
- R7: After the discharge ends, and after the switch has closed again when latched, the block is in idle and the next staircase begins 700 ticks later.
- R8: Crossing pulses during discharge do not shorten it. The `latched` input does not change the timing of detection.
- R9: While `rst` is high, and in the first cycle after it, all outputs are low.
- R10: `test_level` reads 0 whenever `test_on` is low, and `test_on` and `dis_en` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| zc_pulse | input | 1 | Synchronised zero-crossing pulse, one clock wide |
| latched | input | 1 | Converter is in its latched-off state |
| ms_tick | input | 1 | One-clock pulse each millisecond |
| test_on | output | 1 | Enable for the staircase test current |
| test_level | output | LVL_W (2) | Test-current level code, 0 lowest to 3 highest |
| dis_en | output | 1 | Enable for the discharge current sink |
| sw_open | output | 1 | Open the switch from the pass device to the supply pin |

## Verification
Two events can arrive in the same clock: the crossing pulse that aborts the staircase, and the tick that closes a crossing window. At a lower level, that tick would raise the level. At the fourth missed window of level 3, it would confirm the disconnect. The bench drives the pulse and the tick in one clock at both points. It judges the outcome at the ports: the test current must drop with no discharge enable and no level increment, and the next staircase must start a full 700 ticks later.

// File: rtl/acdseq_pkg.sv
package acdseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STEP,
        ST_ISOLATE,
        ST_DISCHARGE,
        ST_RECLOSE
    } seq_state_t;

    typedef struct packed {
        logic test_on;
        logic dis_en;
        logic sw_open;
    } drive_t;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic switch_held_open(input seq_state_t s);
        return (s == ST_ISOLATE) || (s == ST_DISCHARGE) || (s == ST_RECLOSE);
    endfunction

endpackage

// File: rtl/acdseq_tick_timer.sv
module acdseq_tick_timer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit_m1,
    output logic         expire
);
    logic [W-1:0] cnt;

    assign expire = tick && (cnt == limit_m1) && !clr;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= expire ? '0 : cnt + 1'b1;
        end
    end

    // R2
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= limit_m1);

endmodule

// File: rtl/acdseq_miss_counter.sv
module acdseq_miss_counter #(
    parameter int LIMIT = 4,
    parameter int W     = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic hit,
    output logic confirm
);
    logic [W-1:0] cnt;

    assign confirm = hit && (cnt == W'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr || confirm) begin
            cnt <= '0;
        end else if (hit) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R4
    miss_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && !clr && !confirm) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/acdseq_top.sv
module acdseq_top
    import acdseq_pkg::*;
#(
    parameter int IDLE_TICKS = 700,
    parameter int WIN_TICKS  = 12,
    parameter int DIS_TICKS  = 350,
    parameter int MISS_LIMIT = 4,
    parameter int STEPS      = 4,
    parameter int LVL_W      = $clog2(STEPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             zc_pulse,
    input  logic             latched,
    input  logic             ms_tick,
    output logic             test_on,
    output logic [LVL_W-1:0] test_level,
    output logic             dis_en,
    output logic             sw_open
);
    localparam int CNT_W = $clog2(max3(IDLE_TICKS, WIN_TICKS, DIS_TICKS));
    localparam logic [LVL_W-1:0] TOP = LVL_W'(STEPS - 1);

    seq_state_t       state;
    logic [LVL_W-1:0] level;
    logic             lat_q;
    logic [CNT_W-1:0] lim_m1;
    logic             tmr_clr, tmr_exp;
    logic             at_top, miss_hit, miss_clr, confirm;
    drive_t           drv;

    assign at_top   = (state == ST_STEP) && (level == TOP);
    assign tmr_clr  = (state == ST_STEP) && zc_pulse;
    assign miss_hit = at_top && tmr_exp && !zc_pulse;
    assign miss_clr = !at_top || zc_pulse;

    always_comb begin
        unique case (state)
            ST_IDLE:      lim_m1 = CNT_W'(IDLE_TICKS - 1);
            ST_STEP:      lim_m1 = CNT_W'(WIN_TICKS - 1);
            ST_DISCHARGE: lim_m1 = CNT_W'(DIS_TICKS - 1);
            default:      lim_m1 = '0;
        endcase
    end

    acdseq_tick_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .clr      (tmr_clr),
        .tick     (ms_tick),
        .limit_m1 (lim_m1),
        .expire   (tmr_exp)
    );

    acdseq_miss_counter #(.LIMIT(MISS_LIMIT)) u_miss (
        .clk     (clk),
        .rst     (rst),
        .clr     (miss_clr),
        .hit     (miss_hit),
        .confirm (confirm)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            level <= '0;
            lat_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (tmr_exp) begin
                    state <= ST_STEP;
                    level <= '0;
                end
                ST_STEP: if (zc_pulse) begin
                    state <= ST_IDLE;
                    level <= '0;
                end else if (tmr_exp) begin
                    if (level != TOP) begin
                        level <= level + 1'b1;
                    end else if (confirm) begin
                        lat_q <= latched;
                        level <= '0;
                        state <= latched ? ST_ISOLATE : ST_DISCHARGE;
                    end
                end
                ST_ISOLATE: if (tmr_exp) state <= ST_DISCHARGE;
                ST_DISCHARGE: if (tmr_exp) state <= lat_q ? ST_RECLOSE : ST_IDLE;
                ST_RECLOSE: if (tmr_exp) begin
                    state <= ST_IDLE;
                    lat_q <= 1'b0;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        drv.test_on = (state == ST_STEP);
        drv.dis_en  = (state == ST_DISCHARGE);
        drv.sw_open = lat_q && switch_held_open(state);
    end

    assign test_on    = drv.test_on;
    assign test_level = drv.test_on ? level : '0;
    assign dis_en     = drv.dis_en;
    assign sw_open    = drv.sw_open;

    // R10
    exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(test_on && dis_en));

    // R3
    abort_chk: assert property (@(posedge clk) disable iff (rst)
        (test_on && zc_pulse) |=> !test_on);

    // R2
    level_step_chk: assert property (@(posedge clk) disable iff (rst)
        (test_on && $past(test_on)) |->
            (test_level == $past(test_level) || test_level == $past(test_level) + 1'b1));

    // R6
    latched_order_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_open && $rose(dis_en)) |-> $past(sw_open));

    // R6
    reclose_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sw_open) |-> (!dis_en && !$past(dis_en)));

    // R4
    confirm_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dis_en) && !$past(sw_open) |-> ($past(test_on) && $past(test_level) == TOP));

endmodule

// File: tb/acdseq_top_bench.sv
module acdseq_top_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       zc_pulse = 1'b0;
    logic       latched = 1'b0;
    logic       ms_tick = 1'b0;
    logic       test_on, dis_en, sw_open;
    logic [1:0] test_level;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    acdseq_top u_acdseq_top (
        .clk        (clk),
        .rst        (rst),
        .zc_pulse   (zc_pulse),
        .latched    (latched),
        .ms_tick    (ms_tick),
        .test_on    (test_on),
        .test_level (test_level),
        .dis_en     (dis_en),
        .sw_open    (sw_open)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick_once(input logic with_zc = 1'b0);
        ms_tick  = 1'b1;
        zc_pulse = with_zc;
        @(negedge clk);
        ms_tick  = 1'b0;
        zc_pulse = 1'b0;
        @(negedge clk);
    endtask

    task automatic adv(input int n);
        for (int i = 0; i < n; i++) tick_once();
    endtask

    task automatic zc_only();
        zc_pulse = 1'b1;
        @(negedge clk);
        zc_pulse = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        latched = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9", "test_on in reset", int'(test_on), 0);
        chk("R9", "dis_en in reset", int'(dis_en), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R9", "sw_open after reset", int'(sw_open), 0);
        chk("R10", "test_level after reset", int'(test_level), 0);
    endtask

    // Idle timing, staircase levels, abort, crossings in idle ignored
    task automatic t_staircase_abort();
        do_reset();
        adv(300);
        zc_only();
        adv(399);
        chk("R1", "test_on at idle tick 699", int'(test_on), 0);
        adv(1);
        chk("R1", "test_on at idle tick 700", int'(test_on), 1);
        chk("R1", "first level", int'(test_level), 0);
        for (int lv = 0; lv < 3; lv++) begin
            adv(11);
            chk("R2", "level before window end", int'(test_level), lv);
            adv(1);
            chk("R2", "level after window end", int'(test_level), lv + 1);
        end
        adv(20);
        chk("R2", "level holds at top", int'(test_level), 3);
        zc_only();
        chk("R3", "test_on after crossing", int'(test_on), 0);
        chk("R10", "level reads 0 when off", int'(test_level), 0);
        chk("R3", "no discharge on abort", int'(dis_en), 0);
        adv(699);
        chk("R3", "idle restarted, tick 699", int'(test_on), 0);
        adv(1);
        chk("R3", "idle restarted, tick 700", int'(test_on), 1);
        adv(5);
        tick_once(1'b1);
        chk("R3", "abort at level 0 mid window", int'(test_on), 0);
    endtask

    // Crossing coincident with window end, at a lower level and at the confirm point
    task automatic t_coincident();
        do_reset();
        adv(700);
        adv(11);
        tick_once(1'b1);
        chk("R4", "coincident at level 0: test_on", int'(test_on), 0);
        chk("R4", "coincident at level 0: level", int'(test_level), 0);
        adv(700);
        chk("R3", "staircase restart", int'(test_on), 1);
        adv(36 + 47);
        chk("R4", "tick 47 at top: still testing", int'(test_on), 1);
        tick_once(1'b1);
        chk("R4", "coincident confirm: test_on", int'(test_on), 0);
        chk("R4", "coincident confirm: dis_en", int'(dis_en), 0);
        adv(699);
        chk("R4", "coincident confirm: idle 699", int'(test_on), 0);
        adv(1);
        chk("R4", "coincident confirm: idle 700", int'(test_on), 1);
        adv(36 + 36);
        zc_only();
        adv(700 + 36 + 47);
        chk("R3", "misses forgotten after abort", int'(dis_en), 0);
        adv(1);
        chk("R4", "confirm after fresh 4 windows", int'(dis_en), 1);
    endtask

    task automatic t_unlatched();
        do_reset();
        adv(700 + 36 + 47);
        chk("R4", "no confirm at 47 ticks", int'(dis_en), 0);
        adv(1);
        chk("R5", "dis_en at confirm", int'(dis_en), 1);
        chk("R5", "test_on at confirm", int'(test_on), 0);
        chk("R5", "sw_open unlatched", int'(sw_open), 0);
        adv(100);
        zc_only();
        chk("R8", "crossing in discharge ignored", int'(dis_en), 1);
        adv(249);
        chk("R5", "dis_en at tick 349", int'(dis_en), 1);
        chk("R5", "sw_open stays low", int'(sw_open), 0);
        adv(1);
        chk("R5", "dis_en at tick 350", int'(dis_en), 0);
        adv(699);
        chk("R7", "idle after discharge, 699", int'(test_on), 0);
        adv(1);
        chk("R7", "idle after discharge, 700", int'(test_on), 1);
    endtask

    task automatic t_latched();
        do_reset();
        latched = 1'b1;
        adv(699);
        chk("R8", "latched idle 699", int'(test_on), 0);
        adv(1);
        chk("R8", "latched idle 700", int'(test_on), 1);
        adv(36 + 48);
        chk("R6", "switch opens first", int'(sw_open), 1);
        chk("R6", "dis_en waits", int'(dis_en), 0);
        chk("R6", "test off while isolating", int'(test_on), 0);
        adv(1);
        chk("R6", "dis_en one tick later", int'(dis_en), 1);
        chk("R6", "switch still open", int'(sw_open), 1);
        adv(349);
        chk("R6", "dis_en at tick 349", int'(dis_en), 1);
        adv(1);
        chk("R6", "dis_en off at 350", int'(dis_en), 0);
        chk("R6", "switch held after dis_en", int'(sw_open), 1);
        adv(1);
        chk("R6", "switch closes one tick later", int'(sw_open), 0);
        adv(699);
        chk("R7", "latched idle restart 699", int'(test_on), 0);
        adv(1);
        chk("R7", "latched idle restart 700", int'(test_on), 1);
    endtask

    initial begin
        @(negedge clk);
        t_staircase_abort();
        t_coincident();
        t_unlatched();
        t_latched();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule